// File: doc/BRIEF.md
# Bit-Plane Table Block-Adaptive FIR Filter

This block is an adaptive FIR filter that learns its weights one block at a time. Each block holds `L` input samples, and the tap count `N` must be a whole multiple of `L`. The products are formed without multipliers, using distributed arithmetic. Samples are kept in per-group lookup tables. Each table entry holds the sum of one subset of a group's `L` samples. The bits of the weights, taken one bit-plane per cycle, form the table addresses. A shift-and-add accumulator then rebuilds the inner product.

Samples arrive one at a time, each with its desired value, over a valid/ready handshake. When a block is complete, the filter rebuilds the table for the newest group only. Stored samples never move. Instead, the pairing between weights and sample groups rotates by one group, following a circular slot pointer. The filter then produces `L` outputs, one after another, and strobes a block-done flag with the last of them.

After the outputs, the error block is scaled by a right shift. For every tap, the same table-and-bit-plane mechanism then forms the correlation between the error and the input. The resulting update is added to the weights before the next block is accepted.

Top module: `dablms_filter`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` and `blockDone` are 0, all weights are zero, and every stored past sample counts as zero. The first block's outputs are therefore all 0.
- R2: `inReady` stays high until `L` samples have been accepted, where a sample is accepted on a rising edge with `inValid` and `inReady` both high. It is low from the next cycle until the whole block, weight update included, is finished. While `inValid` is low, nothing is accepted and no output appears.
- R3: Output `n` is `floor((sum over t of w[t]*x[n-t]) / 2^15)`. Weights and samples are 16-bit two's complement. Samples from before the first accepted one are zero.
- R4: Each output is saturated to the range -32768..32767.
- R5: Each block produces exactly `L` single-cycle `outValid` pulses, in sample order. `blockDone` is high only together with the last of them.
- R6: After a block's outputs, each weight becomes `w[t] + floor(g[t] / 2^15)`, saturated to 16 bits. Here `g[t] = sum over i of s[i]*x[kL+i-t]`, `s[i] = floor(e[i] / 2^mu)` and `e[i] = d[i] - y[i]`, with `y` the saturated output. The new weights apply from the next block on.
- R7: `muShift` (0..15) sets the step: the scaled error is `e >>> muShift`, an arithmetic shift. A larger value gives a smaller update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample and desired value are present |
| inReady | output | 1 | Filter accepts a sample this cycle |
| inSample | input | 16 | Input sample, two's complement |
| inDesired | input | 16 | Desired response paired with the sample |
| muShift | input | 4 | Step-size shift applied to the error |
| outValid | output | 1 | One-cycle strobe for `outSample` |
| outSample | output | 16 | Saturated filter output |
| blockDone | output | 1 | High with the block's last output |

## Verification
The checks assume that `muShift` stays constant from a block's first accepted sample until `inReady` returns. They also assume that `inDesired` is valid in the same cycle as its sample. The stimulus sets the step before feeding each block and waits for `inReady` before changing it, so both conditions hold.

The stimulus includes mixed-sign blocks under several steps, idle cycles with `inValid` low, and blocks at full scale of both signs. The full-scale blocks drive the weights and the outputs into saturation.

// File: rtl/dablms_pkg.sv
package dablms_pkg;
  localparam int IDXW = 8;

  typedef enum logic [2:0] {
    PH_COLLECT, PH_BUILD, PH_OUT, PH_EMIT, PH_UBUILD, PH_USTEP, PH_UWRITE
  } phase_e;

  typedef struct packed {
    logic            storeSample;
    logic            buildEn;
    logic            outStep;
    logic            outEmit;
    logic            lastOut;
    logic            updBuild;
    logic            updStep;
    logic            wWrite;
    logic [IDXW-1:0] lane;
    logic [IDXW-1:0] buildAddr;
    logic [IDXW-1:0] bitIdx;
    logic [IDXW-1:0] outIdx;
    logic [IDXW-1:0] tapIdx;
    logic [IDXW-1:0] head;
    logic [IDXW-1:0] storeSlot;
  } dp_strobe_t;
endpackage

// File: rtl/dablms_subset_table.sv
module dablms_subset_table #(
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  buildEn,
  input  logic [L-1:0]          buildAddr,
  input  logic [L*W-1:0]        samplesFlat,
  input  logic [L-1:0]          rdAddr,
  output logic signed [W+L-1:0] rdData
);
  localparam int DEPTH = 1 << L;
  localparam int TBW = W + L;

  logic signed [TBW-1:0] mem [DEPTH];
  logic [L-1:0]   prevAddr;
  logic [TBW-1:0] addend;
  int lowBit;

  always_comb begin
    lowBit = 0;
    for (int j = L - 1; j >= 0; j--) begin
      if (buildAddr[j]) lowBit = j;
    end
    prevAddr = buildAddr & (buildAddr - 1'b1);
    addend = {{L{samplesFlat[lowBit*W + W - 1]}}, samplesFlat[lowBit*W +: W]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (buildEn) begin
      mem[buildAddr] <= mem[prevAddr] + addend;
    end
  end

  assign rdData = mem[rdAddr];

  // R3
  build_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    buildEn |-> (buildAddr != '0));
endmodule

// File: rtl/dablms_ctrl.sv
module dablms_ctrl
  import dablms_pkg::*;
#(
  parameter int N  = 8,
  parameter int L  = 4,
  parameter int C  = 16,
  parameter int EB = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output dp_strobe_t stb
);
  localparam int SLOTS = N / L + 1;
  localparam int TBL_LAST = (1 << L) - 1;

  phase_e phase;
  logic [IDXW-1:0] laneCnt, addrCnt, bitCnt, outCnt, tapCnt, head, newSlot;

  assign newSlot = (head == IDXW'(SLOTS - 1)) ? '0 : head + 1'b1;
  assign inReady = (phase == PH_COLLECT);

  always_comb begin
    stb = '0;
    stb.lane      = laneCnt;
    stb.buildAddr = addrCnt;
    stb.bitIdx    = bitCnt;
    stb.outIdx    = outCnt;
    stb.tapIdx    = tapCnt;
    stb.head      = head;
    stb.storeSlot = newSlot;
    unique case (phase)
      PH_COLLECT: stb.storeSample = inValid;
      PH_BUILD:   stb.buildEn = 1'b1;
      PH_OUT:     stb.outStep = 1'b1;
      PH_EMIT: begin
        stb.outEmit = 1'b1;
        stb.lastOut = (outCnt == IDXW'(L - 1));
      end
      PH_UBUILD:  stb.updBuild = 1'b1;
      PH_USTEP:   stb.updStep = 1'b1;
      PH_UWRITE:  stb.wWrite = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_COLLECT;
      laneCnt <= '0;
      addrCnt <= '0;
      bitCnt  <= '0;
      outCnt  <= '0;
      tapCnt  <= '0;
      head    <= '0;
    end else begin
      unique case (phase)
        PH_COLLECT: if (inValid) begin
          if (laneCnt == IDXW'(L - 1)) begin
            laneCnt <= '0;
            head    <= newSlot;
            addrCnt <= IDXW'(1);
            phase   <= PH_BUILD;
          end else begin
            laneCnt <= laneCnt + 1'b1;
          end
        end
        PH_BUILD: begin
          if (addrCnt == IDXW'(TBL_LAST)) begin
            bitCnt <= IDXW'(C - 1);
            outCnt <= '0;
            phase  <= PH_OUT;
          end else begin
            addrCnt <= addrCnt + 1'b1;
          end
        end
        PH_OUT: begin
          if (bitCnt == '0) phase <= PH_EMIT;
          else bitCnt <= bitCnt - 1'b1;
        end
        PH_EMIT: begin
          if (outCnt == IDXW'(L - 1)) begin
            tapCnt  <= '0;
            addrCnt <= IDXW'(1);
            phase   <= PH_UBUILD;
          end else begin
            outCnt <= outCnt + 1'b1;
            bitCnt <= IDXW'(C - 1);
            phase  <= PH_OUT;
          end
        end
        PH_UBUILD: begin
          if (addrCnt == IDXW'(TBL_LAST)) begin
            bitCnt <= IDXW'(EB - 1);
            phase  <= PH_USTEP;
          end else begin
            addrCnt <= addrCnt + 1'b1;
          end
        end
        PH_USTEP: begin
          if (bitCnt == '0) phase <= PH_UWRITE;
          else bitCnt <= bitCnt - 1'b1;
        end
        PH_UWRITE: begin
          if (tapCnt == IDXW'(N - 1)) begin
            phase <= PH_COLLECT;
          end else begin
            tapCnt  <= tapCnt + 1'b1;
            addrCnt <= IDXW'(1);
            phase   <= PH_UBUILD;
          end
        end
        default: phase <= PH_COLLECT;
      endcase
    end
  end

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && laneCnt == IDXW'(L - 1)) |=> !inReady);
endmodule

// File: rtl/dablms_datapath.sv
module dablms_datapath
  import dablms_pkg::*;
#(
  parameter int N    = 8,
  parameter int L    = 4,
  parameter int W    = 16,
  parameter int C    = 16,
  parameter int EB   = 17,
  parameter int MU_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          stb,
  input  logic [W-1:0]        inSample,
  input  logic [W-1:0]        inDesired,
  input  logic [MU_W-1:0]     muShift,
  output logic                outValid,
  output logic [W-1:0]        outSample,
  output logic                blockDone
);
  localparam int P     = N / L;
  localparam int SLOTS = P + 1;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OW    = (L > 1) ? $clog2(L) : 1;
  localparam int TPW   = (N > 1) ? $clog2(N) : 1;
  localparam int CBW   = $clog2(C);
  localparam int EBW   = $clog2(EB);
  localparam int TBW   = W + L;
  localparam int ACCW  = W + L + C + 4;
  localparam int GW    = W + L + EB + 2;
  localparam logic signed [ACCW-1:0] Y_MAX = {{(ACCW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACCW-1:0] Y_MIN = {{(ACCW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [GW-1:0]   K_MAX = {{(GW-C+1){1'b0}}, {(C-1){1'b1}}};
  localparam logic signed [GW-1:0]   K_MIN = {{(GW-C+1){1'b1}}, {(C-1){1'b0}}};

  logic [L*W-1:0]        slotData [SLOTS];
  logic signed [C-1:0]   weights  [N];
  logic signed [W-1:0]   desBuf   [L];
  logic signed [W-1:0]   yBuf     [L];
  logic signed [ACCW-1:0] acc, outSum, yFull;
  logic signed [GW-1:0]  updAcc, updSum, delta, wSum;
  logic signed [W-1:0]   ySat;
  logic signed [C-1:0]   wSat;
  logic [L-1:0]          ewAddr [SLOTS];
  logic signed [TBW-1:0] tblRd  [SLOTS];
  logic [L*W-1:0]        updFlat;
  logic [L-1:0]          updAddr;
  logic signed [TBW-1:0] updRd;
  logic signed [W:0]     errVal [L];
  logic signed [W:0]     esVal  [L];
  logic [CBW-1:0]        cBit;
  logic [EBW-1:0]        eBit;
  logic [TPW-1:0]        tapSel;

  assign cBit   = stb.bitIdx[CBW-1:0];
  assign eBit   = stb.bitIdx[EBW-1:0];
  assign tapSel = stb.tapIdx[TPW-1:0];

  // Weight-to-slot pairing: rotates one group per block with the head pointer
  always_comb begin
    int age, dIdx;
    for (int s = 0; s < SLOTS; s++) begin
      age = (int'(stb.head[SW-1:0]) - s + SLOTS) % SLOTS;
      for (int j = 0; j < L; j++) begin
        dIdx = int'(stb.outIdx[OW-1:0]) + age * L - j;
        ewAddr[s][j] = (dIdx >= 0 && dIdx < N) ? weights[dIdx[TPW-1:0]][cBit] : 1'b0;
      end
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic slotBuild;
      assign slotBuild = stb.buildEn && (stb.head[SW-1:0] == SW'(s));
      dablms_subset_table #(.W(W), .L(L)) u_tbl (
        .clk(clk), .rstN(rstN), .buildEn(slotBuild),
        .buildAddr(stb.buildAddr[L-1:0]), .samplesFlat(slotData[s]),
        .rdAddr(ewAddr[s]), .rdData(tblRd[s])
      );
    end
  endgenerate

  always_comb begin
    outSum = '0;
    for (int s = 0; s < SLOTS; s++) begin
      outSum = outSum + {{(ACCW-TBW){tblRd[s][TBW-1]}}, tblRd[s]};
    end
    yFull = acc >>> (C - 1);
    if (yFull > Y_MAX)      ySat = {1'b0, {(W-1){1'b1}}};
    else if (yFull < Y_MIN) ySat = {1'b1, {(W-1){1'b0}}};
    else                    ySat = yFull[W-1:0];
  end

  // Sample set for one tap, gathered from the circular slots
  always_comb begin
    int m, u, ablk, ln, sl;
    for (int i = 0; i < L; i++) begin
      m    = i - int'(tapSel);
      u    = P * L + m;
      ablk = P - u / L;
      ln   = u % L;
      sl   = (int'(stb.head[SW-1:0]) - ablk + SLOTS) % SLOTS;
      updFlat[i*W +: W] = slotData[sl[SW-1:0]][ln*W +: W];
      errVal[i]  = {desBuf[i][W-1], desBuf[i]} - {yBuf[i][W-1], yBuf[i]};
      esVal[i]   = errVal[i] >>> muShift;
      updAddr[i] = esVal[i][eBit];
    end
  end

  dablms_subset_table #(.W(W), .L(L)) u_updTbl (
    .clk(clk), .rstN(rstN), .buildEn(stb.updBuild),
    .buildAddr(stb.buildAddr[L-1:0]), .samplesFlat(updFlat),
    .rdAddr(updAddr), .rdData(updRd)
  );

  always_comb begin
    updSum = {{(GW-TBW){updRd[TBW-1]}}, updRd};
    delta  = updAcc >>> (W - 1);
    wSum   = {{(GW-C){weights[tapSel][C-1]}}, weights[tapSel]} + delta;
    if (wSum > K_MAX)      wSat = {1'b0, {(C-1){1'b1}}};
    else if (wSum < K_MIN) wSat = {1'b1, {(C-1){1'b0}}};
    else                   wSat = wSum[C-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) slotData[s] <= '0;
      for (int t = 0; t < N; t++) weights[t] <= '0;
      for (int i = 0; i < L; i++) begin
        desBuf[i] <= '0;
        yBuf[i]   <= '0;
      end
      acc       <= '0;
      updAcc    <= '0;
      outValid  <= 1'b0;
      outSample <= '0;
      blockDone <= 1'b0;
    end else begin
      outValid  <= stb.outEmit;
      blockDone <= stb.outEmit && stb.lastOut;
      if (stb.storeSample) begin
        slotData[stb.storeSlot[SW-1:0]][stb.lane[OW-1:0]*W +: W] <= inSample;
        desBuf[stb.lane[OW-1:0]] <= inDesired;
      end
      if (stb.outStep) begin
        if (stb.bitIdx == IDXW'(C - 1)) acc <= -outSum;
        else acc <= (acc <<< 1) + outSum;
      end
      if (stb.outEmit) begin
        outSample <= ySat;
        yBuf[stb.outIdx[OW-1:0]] <= ySat;
      end
      if (stb.updStep) begin
        if (stb.bitIdx == IDXW'(EB - 1)) updAcc <= -updSum;
        else updAcc <= (updAcc <<< 1) + updSum;
      end
      if (stb.wWrite) weights[tapSel] <= wSat;
    end
  end

  // R5
  done_with_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> outValid);
  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R6
  weight_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wWrite |-> !stb.storeSample && !stb.outEmit);
endmodule

// File: rtl/dablms_filter.sv
module dablms_filter
  import dablms_pkg::*;
#(
  parameter int N    = 8,
  parameter int L    = 4,
  parameter int W    = 16,
  parameter int C    = 16,
  parameter int MU_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [W-1:0]    inSample,
  input  logic [W-1:0]    inDesired,
  input  logic [MU_W-1:0] muShift,
  output logic            outValid,
  output logic [W-1:0]    outSample,
  output logic            blockDone
);
  localparam int EB = W + 1;

  dp_strobe_t stb;

  dablms_ctrl #(.N(N), .L(L), .C(C), .EB(EB)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .stb(stb)
  );

  dablms_datapath #(.N(N), .L(L), .W(W), .C(C), .EB(EB), .MU_W(MU_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inSample(inSample),
    .inDesired(inDesired), .muShift(muShift), .outValid(outValid),
    .outSample(outSample), .blockDone(blockDone)
  );

  // R2
  ready_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
endmodule

// File: tb/dablms_filter_bench.sv
module dablms_filter_bench;
  localparam int N = 8;
  localparam int L = 4;
  localparam int W = 16;
  localparam int NB = 6;
  localparam int VEC_X [NB*L] = '{1200, -800, 2500, 300, -1500, 900, -2200, 1800,
                                  700, -300, 1100, -2600, 2000, 1500, -900, -400,
                                  -1200, 2200, 600, -1700, 3000, -3000, 1000, -500};
  localparam int VEC_D [NB*L] = '{2000, -1000, 1500, 500, -2500, 1200, -1800, 2400,
                                  900, -600, 1300, -2000, 2500, 1000, -1500, -700,
                                  -800, 2600, 400, -1900, 2800, -2700, 900, -300};
  localparam int VEC_MU [NB] = '{0, 1, 2, 0, 3, 15};

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic inReady, outValid, blockDone;
  logic [W-1:0] inSample = '0, inDesired = '0, outSample;
  logic [3:0] muShift = '0;

  int checks = 0, failures = 0, cyc = 0;
  longint xs [0:255];
  int nSamp = 0;
  longint wRef [N];
  longint lastOut;

  dablms_filter u_dablms_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSample(inSample), .inDesired(inDesired), .muShift(muShift),
    .outValid(outValid), .outSample(outSample), .blockDone(blockDone)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint xAt(input int idx);
    return (idx < 0) ? 0 : xs[idx];
  endfunction

  task automatic runBlock(input int bx [L], input int bd [L], input int mu);
    longint yExp [L];
    longint es [L];
    int base = nSamp;
    for (int i = 0; i < L; i++) xs[base + i] = bx[i];
    nSamp = base + L;
    // R3 R4: reference outputs with current weights
    for (int i = 0; i < L; i++) begin
      longint s = 0;
      for (int t = 0; t < N; t++) s += wRef[t] * xAt(base + i - t);
      yExp[i] = sat16(s >>> 15);
      es[i] = (longint'(bd[i]) - yExp[i]) >>> mu;
    end
    // R6 R7: reference weight update
    for (int t = 0; t < N; t++) begin
      longint g = 0;
      for (int i = 0; i < L; i++) g += es[i] * xAt(base + i - t);
      wRef[t] = sat16(wRef[t] + (g >>> 15));
    end
    muShift = 4'(mu);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inSample = W'(bx[i]);
      inDesired = W'(bd[i]);
      @(negedge clk);
      inValid = 1'b0;
    end
    for (int i = 0; i < L; i++) begin
      int guard = 0;
      while (!outValid && guard < 3000) begin
        @(negedge clk);
        guard++;
      end
      lastOut = longint'($signed(outSample));
      check(lastOut == yExp[i], "R3/R4 output value", lastOut, yExp[i]);
      check(blockDone == (i == L - 1), "R5 blockDone position", blockDone, (i == L - 1));
      check(!inReady, "R2 ready low while busy", inReady, 0);
      @(negedge clk);
    end
    while (!inReady) @(negedge clk);
  endtask

  initial begin
    int bx [L];
    int bd [L];
    for (int t = 0; t < N; t++) wRef[t] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(blockDone == 1'b0, "R1 blockDone after reset", blockDone, 0);
    rstN = 1'b1;
    // R2 idle: no acceptance, no output
    begin
      int seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (outValid || !inReady) seen++;
      end
      check(seen == 0, "R2 idle without valid", seen, 0);
    end
    // Vector table: R1 (first block zero), R3, R5, R6, R7
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < L; i++) begin
        bx[i] = VEC_X[b*L + i];
        bd[i] = VEC_D[b*L + i];
      end
      runBlock(bx, bd, VEC_MU[b]);
    end
    // R4 R6: full-scale positive drives weights and outputs to saturation
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < L; i++) begin
        bx[i] = 32767;
        bd[i] = 32767;
      end
      runBlock(bx, bd, 0);
    end
    check(lastOut == 32767, "R4 positive saturation", lastOut, 32767);
    // R4: full-scale negative input
    for (int i = 0; i < L; i++) begin
      bx[i] = -32768;
      bd[i] = -32768;
    end
    runBlock(bx, bd, 0);
    check(lastOut == -32768, "R4 negative saturation", lastOut, -32768);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule